// File: doc/BRIEF.md
# Serial Configuration Slave for a Clock Generator

This block is the two-wire serial slave that holds the configuration of a system clock generator. It keeps six 8-bit configuration bytes. A host master changes them with a block write and reads them back with a block read. Only one device address is recognised, at 0xD2 for writing and 0xD3 for reading. Every write carries two header bytes, a command code and a byte count, which the slave acknowledges and then discards. Data always streams from byte 0 upward. A read returns a byte count of six before the data.

The clock and data lines are sampled by the system clock through two-flop synchronizers, and edge detection finds SCL edges and start and stop conditions. SDA is open drain: the block sees the bus level and drives only a pull-low enable. At power-on the block captures four frequency-select strap inputs once. It then offers the clock-control logic the register image and a 5-bit frequency-select code, which byte 0 takes either from the captured straps or from its own bits. Two control flags come from byte 0 as well: spread-spectrum enable and output tristate.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset, byte 0 reads 0x00, bytes 1 to 4 read 0xFF, byte 5 bits 7:4 read 1111, `sda_oe_o` is 0, and `spread_en_o` and `outputs_hiz_o` are 0.
- R2: The slave acknowledges (pulls SDA low during the ninth clock) only the 8-bit address bytes 0xD2 and 0xD3. It does not acknowledge any other address, and it ignores the rest of that transfer until the next start.
- R3: In a write, the two bytes that follow the address are acknowledged and discarded, whatever their values. The third byte after the address lands in byte 0.
- R4: Write data fills bytes 0, 1, 2 and onward in order, and every byte is acknowledged. A stop after any complete byte keeps the bytes already written and leaves the others unchanged.
- R5: Data bytes after the sixth are acknowledged and have no effect on any register.
- R6: After address 0xD3 the slave sends, MSB first, the byte count 6 and then bytes 0 to 5. It moves to the next byte on each master ACK and sends 0xFF past byte 5.
- R7: If byte 0 bit 3 is 0, `fsel_o` = {1'b0, captured straps}. If it is 1, `fsel_o` = {byte0[2], byte0[7:4]}.
- R8: Byte 0 bit 1 drives `spread_en_o` and byte 0 bit 0 drives `outputs_hiz_o`.
- R9: Byte 5 bits 3:0 are read-only and show the bitwise inverse of the captured straps. Writes to those bits have no effect, while bits 7:4 are writable.
- R10: A master NACK in a read ends the transfer and the slave releases SDA. A repeated start begins a new transfer at the address byte.
- R11: The straps are captured once, on the first clock after reset is released. Later changes on `strap_fs_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_fs_i | input | 4 | Frequency-select strap inputs |
| cfg_o | output | 48 | Register image, byte n at bits 8n+7:8n |
| fsel_o | output | 5 | Selected frequency code |
| spread_en_o | output | 1 | Spread-spectrum enable |
| outputs_hiz_o | output | 1 | Tristate-all-outputs request |

## Verification
The bench builds the block with its defaults: six bytes, address 0xD2 and two synchronizer stages. It drives the bus at a quarter period of 25 system clocks, so each edge is seen well after the synchronizer latency. With six bytes a single block write reaches the read-only status byte and runs past the end, so one transfer covers the write-beyond-end and masked-status cases. A behavioural model of the register image and the frequency-select choice is compared with the outputs on every quiet clock. Explicit checks cover the acknowledges, the count and data bytes of a read, a repeated start and a NACK that ends a read.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    // Number of frequency-select straps; the select code is one bit wider.
    localparam int unsigned FS_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_e;

endpackage

// File: rtl/clkcfg_pin_sync.sv
module clkcfg_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.scl_sh   = {q.scl_sh[STAGES-2:0], scl_i};
        d.sda_sh   = {q.sda_sh[STAGES-2:0], sda_i};
        d.scl_prev = q.scl_sh[STAGES-1];
        d.sda_prev = q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '1;
        else         q <= d;
    end

    assign scl_lvl_o  = q.scl_sh[STAGES-1];
    assign sda_lvl_o  = q.sda_sh[STAGES-1];
    assign scl_rise_o = scl_lvl_o & ~q.scl_prev;
    assign scl_fall_o = ~scl_lvl_o & q.scl_prev;
    assign start_o    = scl_lvl_o & q.scl_prev & q.sda_prev & ~sda_lvl_o;
    assign stop_o     = scl_lvl_o & q.scl_prev & ~q.sda_prev & sda_lvl_o;

    // R2: start and stop are exclusive, and neither coincides with an SCL edge
    a_r2_cond_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({start_o, stop_o, scl_rise_o, scl_fall_o}) <= 1);

endmodule

// File: rtl/clkcfg_i2c_engine.sv
module clkcfg_i2c_engine
    import clkcfg_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 6,
    parameter logic [7:0]  DEV_ADDR  = 8'hD2
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         scl_lvl_i,
    input  logic                         sda_i,
    input  logic                         scl_rise_i,
    input  logic                         scl_fall_i,
    input  logic                         start_i,
    input  logic                         stop_i,
    input  logic [NUM_BYTES*8-1:0]       cfg_i,
    output logic                         sda_oe_o,
    output logic                         wr_en_o,
    output logic [$clog2(NUM_BYTES)-1:0] wr_idx_o,
    output logic [7:0]                   wr_data_o
);
    localparam int unsigned IDX_W  = $clog2(NUM_BYTES + 3);
    localparam int unsigned BIDX_W = $clog2(NUM_BYTES);
    localparam int          HDR_WR = 2;  // command code + byte count
    localparam int          HDR_RD = 1;  // byte count
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    typedef struct packed {
        phase_e           st;
        logic [3:0]       bitcnt;
        logic [7:0]       sh;
        logic             rw;
        logic [IDX_W-1:0] idx;
        logic             sda_oe;
        logic             ack_ok;
    } eng_t;

    eng_t q, d;
    logic [IDX_W-1:0] idx_inc;
    logic             data_slot;
    logic [7:0]       nxt;

    function automatic logic [7:0] tx_pick(input logic [IDX_W-1:0] i);
        if (i == '0) return 8'(NUM_BYTES);
        if (int'(i) - HDR_RD < int'(NUM_BYTES)) return cfg_i[(int'(i) - HDR_RD)*8 +: 8];
        return 8'hFF;
    endfunction

    assign idx_inc   = (q.idx == IDX_MAX) ? q.idx : q.idx + 1'b1;
    assign data_slot = (int'(q.idx) >= HDR_WR) && (int'(q.idx) - HDR_WR < int'(NUM_BYTES));

    always_comb begin
        d         = q;
        wr_en_o   = 1'b0;
        wr_idx_o  = '0;
        wr_data_o = q.sh;
        nxt       = 8'h00;
        if (start_i) begin
            d.st     = PH_ADDR;
            d.bitcnt = '0;
            d.idx    = '0;
            d.sda_oe = 1'b0;
        end else if (stop_i) begin
            d.st     = PH_IDLE;
            d.sda_oe = 1'b0;
        end else begin
            unique case (q.st)
                PH_ADDR, PH_RX: begin
                    if (scl_rise_i && q.bitcnt != 4'd8) begin
                        d.sh     = {q.sh[6:0], sda_i};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall_i && q.bitcnt == 4'd8) begin
                        d.bitcnt = '0;
                        if (q.st == PH_ADDR) begin
                            if (q.sh[7:1] == DEV_ADDR[7:1]) begin
                                d.rw     = q.sh[0];
                                d.st     = PH_ADDR_ACK;
                                d.sda_oe = 1'b1;
                            end else begin
                                d.st = PH_IDLE;
                            end
                        end else begin
                            d.st     = PH_RX_ACK;
                            d.sda_oe = 1'b1;
                            if (data_slot) begin
                                wr_en_o  = 1'b1;
                                wr_idx_o = BIDX_W'(int'(q.idx) - HDR_WR);
                            end
                        end
                    end
                end
                PH_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        d.idx = '0;
                        if (q.rw) begin
                            nxt      = tx_pick('0);
                            d.sh     = nxt;
                            d.sda_oe = ~nxt[7];
                            d.st     = PH_TX;
                        end else begin
                            d.sda_oe = 1'b0;
                            d.st     = PH_RX;
                        end
                    end
                end
                PH_RX_ACK: begin
                    if (scl_fall_i) begin
                        d.sda_oe = 1'b0;
                        d.idx    = idx_inc;
                        d.st     = PH_RX;
                    end
                end
                PH_TX: begin
                    if (scl_fall_i) begin
                        if (q.bitcnt == 4'd7) begin
                            d.bitcnt = '0;
                            d.sda_oe = 1'b0;
                            d.ack_ok = 1'b0;
                            d.st     = PH_TX_ACK;
                        end else begin
                            d.bitcnt = q.bitcnt + 4'd1;
                            d.sh     = {q.sh[6:0], 1'b1};
                            d.sda_oe = ~q.sh[6];
                        end
                    end
                end
                PH_TX_ACK: begin
                    if (scl_rise_i) begin
                        d.ack_ok = ~sda_i;
                    end else if (scl_fall_i) begin
                        if (q.ack_ok) begin
                            d.idx    = idx_inc;
                            nxt      = tx_pick(idx_inc);
                            d.sh     = nxt;
                            d.sda_oe = ~nxt[7];
                            d.st     = PH_TX;
                        end else begin
                            d.st = PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{st: PH_IDLE, default: '0};
        else         q <= d;
    end

    assign sda_oe_o = q.sda_oe;

    // R2: never pull SDA while not addressed
    a_r2_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == PH_IDLE) |-> !sda_oe_o);
    // R2: SDA drive changes only while SCL is low, or on a start/stop
    a_r2_sda_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sda_oe_o != $past(sda_oe_o)) |-> (!$past(scl_lvl_i) || $past(stop_i) || $past(start_i)));
    // R10: a stop releases the bus
    a_r10_release_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> !sda_oe_o);
    // R5: no write strobe outside the register range
    a_r5_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> (int'(wr_idx_o) < int'(NUM_BYTES)));

endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
    import clkcfg_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 6
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wr_en_i,
    input  logic [$clog2(NUM_BYTES)-1:0] wr_idx_i,
    input  logic [7:0]                   wr_data_i,
    input  logic [FS_W-1:0]              strap_i,
    output logic [NUM_BYTES*8-1:0]       cfg_o,
    output logic [FS_W:0]                fsel_o,
    output logic                         spread_en_o,
    output logic                         hiz_o
);
    localparam int unsigned STATUS_IDX = NUM_BYTES - 1;
    localparam int unsigned SEL_BIT    = 3;
    localparam int unsigned HI_BIT     = 2;
    localparam int unsigned SS_BIT     = 1;
    localparam int unsigned HIZ_BIT    = 0;
    localparam logic [NUM_BYTES-2:0][7:0] RST_REGS = {{(NUM_BYTES-2){8'hFF}}, 8'h00};

    typedef struct packed {
        logic [NUM_BYTES-2:0][7:0] regs;
        logic [7-FS_W:0]           st_hi;
        logic [FS_W-1:0]           strap;
        logic                      done;
    } bank_t;

    bank_t q, d;
    logic [7:0] byte0;

    always_comb begin
        d = q;
        if (!q.done) begin
            d.strap = strap_i;
            d.done  = 1'b1;
        end
        if (wr_en_i) begin
            if (int'(wr_idx_i) == int'(STATUS_IDX)) d.st_hi = wr_data_i[7:FS_W];
            else                                    d.regs[wr_idx_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{regs: RST_REGS, st_hi: '1, strap: '0, done: 1'b0};
        else         q <= d;
    end

    for (genvar b = 0; b < int'(NUM_BYTES) - 1; b++) begin : g_view
        assign cfg_o[b*8 +: 8] = q.regs[b];
    end
    assign cfg_o[STATUS_IDX*8 +: 8] = {q.st_hi, ~q.strap};

    assign byte0       = q.regs[0];
    assign fsel_o      = byte0[SEL_BIT] ? {byte0[HI_BIT], byte0[7:4]} : {1'b0, q.strap};
    assign spread_en_o = byte0[SS_BIT];
    assign hiz_o       = byte0[HIZ_BIT];

    // R11: straps captured once and then frozen
    a_r11_strap_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.done |=> (q.done && $stable(q.strap)));
    // R9: a write to the status byte leaves its read-only bits alone
    a_r9_status_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.done && wr_en_i && int'(wr_idx_i) == int'(STATUS_IDX))
            |=> $stable(cfg_o[STATUS_IDX*8 +: FS_W]));

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
    import clkcfg_pkg::*;
#(
    parameter int unsigned NUM_BYTES   = 6,
    parameter logic [7:0]  DEV_ADDR    = 8'hD2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    input  logic [FS_W-1:0]        strap_fs_i,
    output logic [NUM_BYTES*8-1:0] cfg_o,
    output logic [FS_W:0]          fsel_o,
    output logic                   spread_en_o,
    output logic                   outputs_hiz_o
);
    localparam int unsigned BIDX_W = $clog2(NUM_BYTES);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start, stop;
    logic wr_en;
    logic [BIDX_W-1:0] wr_idx;
    logic [7:0] wr_data;

    clkcfg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_lvl_o  (scl_lvl),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start),
        .stop_o     (stop)
    );

    clkcfg_i2c_engine #(.NUM_BYTES(NUM_BYTES), .DEV_ADDR(DEV_ADDR)) u_engine (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_lvl_i  (scl_lvl),
        .sda_i      (sda_lvl),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start),
        .stop_i     (stop),
        .cfg_i      (cfg_o),
        .sda_oe_o   (sda_oe_o),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data)
    );

    clkcfg_regbank #(.NUM_BYTES(NUM_BYTES)) u_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en),
        .wr_idx_i    (wr_idx),
        .wr_data_i   (wr_data),
        .strap_i     (strap_fs_i),
        .cfg_o       (cfg_o),
        .fsel_o      (fsel_o),
        .spread_en_o (spread_en_o),
        .hiz_o       (outputs_hiz_o)
    );

endmodule

// File: tb/clkcfg_i2c_slave_bench.sv
module clkcfg_i2c_slave_bench;
    localparam int NB = 6;
    localparam int Q  = 25;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, scl, sda_m, sda_oe, sda_bus, ss, hiz;
    logic [3:0] strap;
    logic [NB*8-1:0] cfg;
    logic [4:0] fsel;

    assign sda_bus = sda_m & ~sda_oe;

    clkcfg_i2c_slave u_clkcfg_i2c_slave (
        .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .strap_fs_i(strap), .cfg_o(cfg), .fsel_o(fsel), .spread_en_o(ss), .outputs_hiz_o(hiz)
    );

    int n_cmp = 0, n_bad = 0, quiet = 0;
    bit cmp_on = 1'b0;
    logic [7:0] m_reg [NB];
    logic [3:0] m_strap;

    function automatic logic [7:0] m_view(int i);
        return (i == NB-1) ? {m_reg[i][7:4], ~m_strap} : m_reg[i];
    endfunction

    function automatic logic [4:0] m_fsel();
        return m_reg[0][3] ? {m_reg[0][2], m_reg[0][7:4]} : {1'b0, m_strap};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model compared on every settled clock (R4 R7 R8 R9)
    always @(negedge clk) begin
        if (cmp_on) begin
            if (quiet > 0) quiet--;
            else begin
                for (int i = 0; i < NB; i++) chk("R4 image byte", cfg[i*8 +: 8], m_view(i));
                chk("R7 fsel", fsel, m_fsel());
                chk("R8 spread", ss, m_reg[0][1]);
                chk("R8 hiz", hiz, m_reg[0][0]);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; tick(Q);
        scl = 1'b1; tick(Q);
        s = sda_bus; tick(Q);
        scl = 1'b0; quiet = 12;
    endtask

    task automatic start_c();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0; quiet = 12; tick(Q);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, input int pos, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(b[i], s);
            if (i == 0 && pos >= 0 && pos < NB) m_reg[pos] = b;
            tick(Q);
        end
        clk_bit(1'b1, s);
        ack = ~s;
        tick(Q);
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
            tick(Q);
        end
        clk_bit(~mack, s);
        tick(Q);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] rb;
        scl = 1'b1; sda_m = 1'b1; strap = 4'b1010; rst_n = 1'b0;
        m_strap = 4'b1010;
        m_reg[0] = 8'h00;
        for (int i = 1; i < NB; i++) m_reg[i] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        cmp_on = 1'b1;

        // R1 reset state
        chk("R1 cfg reset", cfg, {8'hF5, 32'hFFFF_FFFF, 8'h00});
        chk("R1 fsel reset", fsel, 5'b01010);
        chk("R1 flags reset", {ss, hiz, sda_oe}, 3'b000);

        // R11 strap change after capture has no effect
        strap = 4'b0101;
        tick(10);
        chk("R11 fsel frozen", fsel, 5'b01010);
        chk("R11 status frozen", cfg[47:40], 8'hF5);

        // R2 R3 R4 R7 R8: short write then stop
        start_c();
        wr_byte(8'hD2, -1, ack); chk("R2 write addr ack", ack, 1'b1);
        wr_byte(8'h55, -1, ack); chk("R3 cmd ack", ack, 1'b1);
        wr_byte(8'h07, -1, ack); chk("R3 count ack", ack, 1'b1);
        wr_byte(8'h5B, 0, ack);  chk("R4 data0 ack", ack, 1'b1);
        wr_byte(8'h12, 1, ack);  chk("R4 data1 ack", ack, 1'b1);
        stop_c();
        chk("R3 header discarded", cfg[7:0], 8'h5B);
        chk("R4 partial kept", cfg[15:8], 8'h12);
        chk("R4 rest unchanged", cfg[47:16], 32'hF5FF_FFFF);
        chk("R7 register select", fsel, 5'b00101);
        chk("R8 spread and hiz", {ss, hiz}, 2'b11);

        // R2 foreign address ignored
        start_c();
        wr_byte(8'hA0, -1, ack); chk("R2 foreign nack", ack, 1'b0);
        wr_byte(8'h00, -1, ack); chk("R2 ignored byte nack", ack, 1'b0);
        stop_c();
        chk("R2 image unchanged", cfg, {8'hF5, 24'hFFFFFF, 8'h12, 8'h5B});

        // R5 R9 R7 R8: full write running past the end
        start_c();
        wr_byte(8'hD2, -1, ack);
        wr_byte(8'h00, -1, ack);
        wr_byte(8'h00, -1, ack);
        wr_byte(8'hF6, 0, ack);
        wr_byte(8'h11, 1, ack);
        wr_byte(8'h22, 2, ack);
        wr_byte(8'h33, 3, ack);
        wr_byte(8'h44, 4, ack);
        wr_byte(8'h00, 5, ack);  chk("R4 byte5 ack", ack, 1'b1);
        wr_byte(8'h99, 6, ack);  chk("R5 extra ack", ack, 1'b1);
        wr_byte(8'h77, 7, ack);  chk("R5 extra ack 2", ack, 1'b1);
        stop_c();
        chk("R9 status read-only", cfg[47:40], 8'h05);
        chk("R5 no spill", cfg[39:8], 32'h4433_2211);
        chk("R7 strap select", fsel, 5'b01010);
        chk("R8 spread on hiz off", {ss, hiz}, 2'b10);

        // R6 R10: block read ended by NACK
        start_c();
        wr_byte(8'hD3, -1, ack); chk("R6 read addr ack", ack, 1'b1);
        rd_byte(1'b1, rb); chk("R6 byte count", rb, 8'h06);
        for (int i = 0; i < NB; i++) begin
            rd_byte(i != NB-1, rb);
            chk("R6 read data", rb, m_view(i));
        end
        chk("R10 released after nack", sda_oe, 1'b0);
        stop_c();

        // R10 repeated start, then read back
        start_c();
        wr_byte(8'hD2, -1, ack);
        wr_byte(8'hAA, -1, ack);
        wr_byte(8'h01, -1, ack);
        wr_byte(8'h08, 0, ack);
        start_c();
        wr_byte(8'hD3, -1, ack); chk("R10 restart addr ack", ack, 1'b1);
        rd_byte(1'b1, rb); chk("R10 restart count", rb, 8'h06);
        rd_byte(1'b0, rb); chk("R10 restart byte0", rb, 8'h08);
        stop_c();
        chk("R7 register select zero", fsel, 5'b00000);
        chk("R10 bus free", sda_oe, 1'b0);

        tick(10);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule